// File: doc/BRIEF.md
# Write-Window Block State Tracker

This block keeps a per-block record for the write window that is currently open. Each block of the window is clean, dirty, or erased. The host side issues range commands that give a starting block and a block count, both measured from the first block of the window. Each command marks every block in the range as dirty (written) or as erased. A byte read that lands in an erased block is overridden so that it returns 0xFF. Reads of clean or dirty blocks pass through untouched.

When a flush is requested, the tracker walks the window from block zero upward. It emits one operation for each marked block, tagged as a program or an erase, and waits for the storage side to acknowledge each operation before it emits the next. After the last operation it clears every marking and signals completion. Closing the window, whether the close is explicit or implied by opening another window, discards all markings at once and abandons any flush in progress. The flash programming itself is done elsewhere.

Top module: `wbt_tracker`

## Requirements
- R1: After reset every block is clean, `busy`, `flush_valid`, `flush_done`, `mark_ok`, `mark_rej` and `rd_ovr_en` are all low.
- R2: An accepted mark command (`mark_erase`=0 for dirty, 1 for erased) sets every block i with `mark_off` <= i < `mark_off`+`mark_cnt` to that state and pulses `mark_ok` in the cycle after the command.
- R3: A mark command whose `mark_off`+`mark_cnt` exceeds `win_blocks` (or NBLK) pulses `mark_rej` in the following cycle and leaves every block unchanged.
- R4: A read of byte address `rd_addr` (block index = `rd_addr` >> OFS_W) gives, one cycle later, `rd_ovr_en`=1 and `rd_ovr_data`=0xFF when that block is erased, and `rd_ovr_en`=0 with `rd_ovr_data`=0x00 otherwise.
- R5: A later mark overrides an earlier one: marking an erased block dirty makes it dirty, and marking a dirty block erased makes it erased.
- R6: A flush emits exactly one operation per marked block, in ascending block order. `flush_is_erase`=1 marks an erased block and 0 a dirty block. Each operation holds `flush_valid`, `flush_blk` and `flush_is_erase` steady until `flush_ack`.
- R7: After the last operation is acknowledged, `flush_done` pulses, `busy` is low in that cycle, and every block is clean. A flush with no marked blocks completes with no operations.
- R8: From `flush_start` until completion `busy` is high, and any mark command is rejected with `mark_rej` and no state change, while existing markings still drive the read override.
- R9: `win_close` clears every marking and abandons any flush: in the next cycle `busy` and `flush_valid` are low and no `flush_done` is raised.
- R10: A mark command with `mark_cnt`=0 and `mark_off` <= `win_blocks` is accepted and changes no block.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_blocks | input | CNT_W | Size of the open window in blocks |
| win_close | input | 1 | Window closed: discard all markings |
| mark_valid | input | 1 | Range mark command strobe |
| mark_erase | input | 1 | 1 marks the range erased, 0 marks it dirty |
| mark_off | input | CNT_W | First block of the range |
| mark_cnt | input | CNT_W | Number of blocks in the range |
| mark_ok | output | 1 | Command accepted (one cycle later) |
| mark_rej | output | 1 | Command rejected (one cycle later) |
| rd_valid | input | 1 | Byte read strobe |
| rd_addr | input | ADDR_W | Byte address within the window |
| rd_ovr_en | output | 1 | Read data must be replaced |
| rd_ovr_data | output | 8 | Replacement byte |
| flush_start | input | 1 | Begin a flush |
| flush_ack | input | 1 | Current flush operation finished |
| flush_valid | output | 1 | Flush operation pending |
| flush_blk | output | IDX_W | Block of the pending operation |
| flush_is_erase | output | 1 | Pending operation is an erase |
| flush_done | output | 1 | Flush finished, markings cleared |
| busy | output | 1 | Flush in progress |

## Verification
The bench builds the tracker with NBLK=16 and OFS_W=4. With these values a full-window mark, a walk over every block and the last-block boundary all take only a handful of cycles. Most tests use a 12-block window. This places the bounds check below NBLK, so a range ending on block 11 is accepted and one ending a block later is rejected. A later test widens the window to all 16 blocks to reach the top index of the map and of the flush cursor.

// File: rtl/wbt_pkg.sv
package wbt_pkg;
  typedef enum logic [1:0] {
    BLK_CLEAN  = 2'b00,
    BLK_DIRTY  = 2'b01,
    BLK_ERASED = 2'b10
  } blk_state_e;

  typedef enum logic [1:0] {
    FW_IDLE  = 2'b00,
    FW_SCAN  = 2'b01,
    FW_ISSUE = 2'b10
  } walk_state_e;
endpackage

// File: rtl/wbt_rst_sync.sv
module wbt_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/wbt_range_decode.sv
module wbt_range_decode #(
  parameter int unsigned NBLK  = 64,
  parameter int unsigned CNT_W = $clog2(NBLK + 1)
) (
  input  logic [CNT_W-1:0] off,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] win_blocks,
  output logic             in_bounds,
  output logic [NBLK-1:0]  hit_mask
);
  logic [CNT_W:0] range_end;
  logic [CNT_W:0] limit;

  // One extra bit so offset + count never wraps.
  assign range_end = {1'b0, off} + {1'b0, cnt};
  assign limit     = (win_blocks > CNT_W'(NBLK)) ? (CNT_W+1)'(NBLK) : {1'b0, win_blocks};
  assign in_bounds = (range_end <= limit);

  for (genvar g = 0; g < NBLK; g++) begin : g_hit
    localparam int unsigned BI = g;
    assign hit_mask[g] = ({1'b0, off} <= (CNT_W+1)'(BI)) && ((CNT_W+1)'(BI) < range_end);
  end
endmodule

// File: rtl/wbt_state_map.sv
module wbt_state_map
  import wbt_pkg::*;
#(
  parameter int unsigned NBLK = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clear_all,
  input  logic            wr_en,
  input  logic [NBLK-1:0] wr_mask,
  input  logic            wr_erase,
  output logic [NBLK-1:0] marked_vec,
  output logic [NBLK-1:0] erased_vec
);
  for (genvar g = 0; g < NBLK; g++) begin : g_cell
    blk_state_e st_q, st_d;
    logic       cell_en;

    assign cell_en = clear_all | (wr_en & wr_mask[g]);

    always_comb begin
      st_d = st_q;
      if (clear_all)                st_d = BLK_CLEAN;
      else if (wr_en && wr_mask[g]) st_d = wr_erase ? BLK_ERASED : BLK_DIRTY;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       st_q <= BLK_CLEAN;
      else if (cell_en) st_q <= st_d;
    end

    assign marked_vec[g] = (st_q != BLK_CLEAN);
    assign erased_vec[g] = (st_q == BLK_ERASED);
  end
endmodule

// File: rtl/wbt_flush_walker.sv
module wbt_flush_walker
  import wbt_pkg::*;
#(
  parameter int unsigned NBLK  = 64,
  parameter int unsigned IDX_W = $clog2(NBLK),
  parameter int unsigned CNT_W = $clog2(NBLK + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             abort,
  input  logic [NBLK-1:0]  marked_vec,
  input  logic [NBLK-1:0]  erased_vec,
  input  logic             ack,
  output logic             busy,
  output logic             op_valid,
  output logic [IDX_W-1:0] op_blk,
  output logic             op_erase,
  output logic             clear_all,
  output logic             done
);
  walk_state_e      st_q, st_d;
  logic [CNT_W-1:0] cursor_q, cursor_d;
  logic [IDX_W-1:0] blk_q, blk_d;
  logic             erase_q, erase_d;
  logic             done_q, done_d;
  logic             found;
  logic [IDX_W-1:0] found_idx;
  logic             op_en;

  // Lowest marked block at or above the cursor.
  always_comb begin
    found     = 1'b0;
    found_idx = '0;
    for (int i = NBLK - 1; i >= 0; i--) begin
      if (marked_vec[i] && (CNT_W'(i) >= cursor_q)) begin
        found     = 1'b1;
        found_idx = IDX_W'(i);
      end
    end
  end

  always_comb begin
    st_d      = st_q;
    cursor_d  = cursor_q;
    blk_d     = blk_q;
    erase_d   = erase_q;
    done_d    = 1'b0;
    clear_all = 1'b0;
    unique case (st_q)
      FW_IDLE: begin
        if (start) begin
          st_d     = FW_SCAN;
          cursor_d = '0;
        end
      end
      FW_SCAN: begin
        if (found) begin
          blk_d   = found_idx;
          erase_d = erased_vec[found_idx];
          st_d    = FW_ISSUE;
        end else begin
          clear_all = 1'b1;
          done_d    = 1'b1;
          st_d      = FW_IDLE;
        end
      end
      FW_ISSUE: begin
        if (ack) begin
          cursor_d = CNT_W'(blk_q) + CNT_W'(1);
          st_d     = FW_SCAN;
        end
      end
      default: st_d = FW_IDLE;
    endcase
    if (abort) begin
      st_d      = FW_IDLE;
      done_d    = 1'b0;
      clear_all = 1'b0;
    end
  end

  assign op_en = (st_q == FW_SCAN) && found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= FW_IDLE;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      done_q <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      cursor_q <= '0;
    else if (st_q != FW_SCAN)        cursor_q <= cursor_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q   <= '0;
      erase_q <= 1'b0;
    end else if (op_en) begin
      blk_q   <= blk_d;
      erase_q <= erase_d;
    end
  end

  assign busy      = (st_q != FW_IDLE);
  assign op_valid  = (st_q == FW_ISSUE);
  assign op_blk    = blk_q;
  assign op_erase  = erase_q;
  assign done      = done_q;
endmodule

// File: rtl/wbt_read_override.sv
module wbt_read_override #(
  parameter int unsigned NBLK  = 64,
  parameter int unsigned IDX_W = $clog2(NBLK)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_valid,
  input  logic [IDX_W-1:0] rd_blk,
  input  logic [NBLK-1:0]  erased_vec,
  output logic             ovr_en,
  output logic [7:0]       ovr_data
);
  logic en_q, en_d;

  assign en_d = rd_valid & erased_vec[rd_blk];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= en_d;
  end

  assign ovr_en   = en_q;
  assign ovr_data = {8{en_q}};
endmodule

// File: rtl/wbt_tracker.sv
module wbt_tracker #(
  parameter int unsigned NBLK  = 64,
  parameter int unsigned OFS_W = 12,
  localparam int unsigned IDX_W  = $clog2(NBLK),
  localparam int unsigned CNT_W  = $clog2(NBLK + 1),
  localparam int unsigned ADDR_W = IDX_W + OFS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  win_blocks,
  input  logic              win_close,
  input  logic              mark_valid,
  input  logic              mark_erase,
  input  logic [CNT_W-1:0]  mark_off,
  input  logic [CNT_W-1:0]  mark_cnt,
  output logic              mark_ok,
  output logic              mark_rej,
  input  logic              rd_valid,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic              rd_ovr_en,
  output logic [7:0]        rd_ovr_data,
  input  logic              flush_start,
  input  logic              flush_ack,
  output logic              flush_valid,
  output logic [IDX_W-1:0]  flush_blk,
  output logic              flush_is_erase,
  output logic              flush_done,
  output logic              busy
);
  logic            rst_n_i;
  logic            in_bounds;
  logic [NBLK-1:0] hit_mask;
  logic [NBLK-1:0] marked_vec;
  logic [NBLK-1:0] erased_vec;
  logic            walk_clear;
  logic            map_clear;
  logic            mark_acc;
  logic            ok_q, rej_q, ok_d, rej_d;
  logic            unused_ofs;

  wbt_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_i)
  );

  wbt_range_decode #(.NBLK(NBLK), .CNT_W(CNT_W)) u_range (
    .off        (mark_off),
    .cnt        (mark_cnt),
    .win_blocks (win_blocks),
    .in_bounds  (in_bounds),
    .hit_mask   (hit_mask)
  );

  assign mark_acc  = mark_valid & ~busy & ~win_close & in_bounds;
  assign map_clear = win_close | walk_clear;
  assign ok_d      = mark_acc;
  assign rej_d     = mark_valid & ~mark_acc;

  wbt_state_map #(.NBLK(NBLK)) u_map (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .clear_all  (map_clear),
    .wr_en      (mark_acc),
    .wr_mask    (hit_mask),
    .wr_erase   (mark_erase),
    .marked_vec (marked_vec),
    .erased_vec (erased_vec)
  );

  wbt_flush_walker #(.NBLK(NBLK), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_walk (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .start      (flush_start),
    .abort      (win_close),
    .marked_vec (marked_vec),
    .erased_vec (erased_vec),
    .ack        (flush_ack),
    .busy       (busy),
    .op_valid   (flush_valid),
    .op_blk     (flush_blk),
    .op_erase   (flush_is_erase),
    .clear_all  (walk_clear),
    .done       (flush_done)
  );

  wbt_read_override #(.NBLK(NBLK), .IDX_W(IDX_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n_i),
    .rd_valid   (rd_valid),
    .rd_blk     (rd_addr[ADDR_W-1:OFS_W]),
    .erased_vec (erased_vec),
    .ovr_en     (rd_ovr_en),
    .ovr_data   (rd_ovr_data)
  );

  assign unused_ofs = ^rd_addr[OFS_W-1:0];

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      ok_q  <= 1'b0;
      rej_q <= 1'b0;
    end else begin
      ok_q  <= ok_d;
      rej_q <= rej_d;
    end
  end

  assign mark_ok  = ok_q;
  assign mark_rej = rej_q;
endmodule

// File: rtl/wbt_tracker_chk.sv
module wbt_tracker_chk #(
  parameter int unsigned NBLK = 64,
  localparam int unsigned IDX_W = $clog2(NBLK)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             win_close,
  input logic             mark_valid,
  input logic             mark_ok,
  input logic             mark_rej,
  input logic             busy,
  input logic             flush_valid,
  input logic             flush_ack,
  input logic [IDX_W-1:0] flush_blk,
  input logic             flush_is_erase,
  input logic             flush_done,
  input logic             rd_ovr_en,
  input logic [7:0]       rd_ovr_data
);
  logic             have_prev;
  logic [IDX_W-1:0] prev_blk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_prev <= 1'b0;
      prev_blk  <= '0;
    end else if (!busy) begin
      have_prev <= 1'b0;
    end else if (flush_valid && flush_ack) begin
      have_prev <= 1'b1;
      prev_blk  <= flush_blk;
    end
  end

  // R2 / R3: a command gets exactly one verdict
  a_r2_single_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    !(mark_ok && mark_rej));

  // R4: override data is all ones
  a_r4_override_ff: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ovr_en |-> (rd_ovr_data == 8'hFF));

  // R6: operation held until acknowledged
  a_r6_hold_until_ack: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_valid && !flush_ack && !win_close) |=>
      (flush_valid && $stable(flush_blk) && $stable(flush_is_erase)));

  // R6: ascending order within one flush
  a_r6_ascending: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(flush_valid) && have_prev) |-> (flush_blk > prev_blk));

  // R7: completion leaves the tracker idle
  a_r7_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    flush_done |-> (!busy && !flush_valid));

  // R8: marks during a flush are refused
  a_r8_busy_rejects: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mark_valid) |=> (mark_rej && !mark_ok));

  // R9: close abandons the flush
  a_r9_close_idle: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (!busy && !flush_valid && !flush_done));
endmodule

bind wbt_tracker wbt_tracker_chk #(.NBLK(NBLK)) u_chk (.*);

// File: tb/test_wbt_tracker.sv
`timescale 1ns/1ps
module test_wbt_tracker;
  localparam int NB  = 16;
  localparam int OW  = 4;
  localparam int IW  = 4;
  localparam int CW  = 5;
  localparam int AW  = IW + OW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [CW-1:0] win_blocks;
  logic          win_close, mark_valid, mark_erase;
  logic [CW-1:0] mark_off, mark_cnt;
  logic          mark_ok, mark_rej;
  logic          rd_valid;
  logic [AW-1:0] rd_addr;
  logic          rd_ovr_en;
  logic [7:0]    rd_ovr_data;
  logic          flush_start, flush_ack, flush_valid, flush_is_erase, flush_done, busy;
  logic [IW-1:0] flush_blk;

  int vectors = 0;
  int miscmp  = 0;
  int model [NB];   // 0 clean, 1 dirty, 2 erased

  always #2.5 clk = ~clk;

  wbt_tracker #(.NBLK(NB), .OFS_W(OW)) i_wbt_tracker (
    .clk(clk), .rst_n(rst_n), .win_blocks(win_blocks), .win_close(win_close),
    .mark_valid(mark_valid), .mark_erase(mark_erase), .mark_off(mark_off),
    .mark_cnt(mark_cnt), .mark_ok(mark_ok), .mark_rej(mark_rej),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ovr_en(rd_ovr_en),
    .rd_ovr_data(rd_ovr_data), .flush_start(flush_start), .flush_ack(flush_ack),
    .flush_valid(flush_valid), .flush_blk(flush_blk), .flush_is_erase(flush_is_erase),
    .flush_done(flush_done), .busy(busy)
  );

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      miscmp++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic mark(input int off, input int cnt, input bit er,
                      output bit ok, output bit rej);
    @(negedge clk);
    mark_valid = 1'b1; mark_erase = er;
    mark_off = CW'(off); mark_cnt = CW'(cnt);
    @(negedge clk);
    mark_valid = 1'b0;
    ok = mark_ok; rej = mark_rej;
  endtask

  task automatic model_mark(input int off, input int cnt, input bit er);
    for (int i = off; i < off + cnt; i++) model[i] = er ? 2 : 1;
  endtask

  task automatic read_blk(input int b, output bit en, output int data);
    @(negedge clk);
    rd_valid = 1'b1; rd_addr = {IW'(b), OW'(b + 5)};
    @(negedge clk);
    rd_valid = 1'b0;
    en = rd_ovr_en; data = rd_ovr_data;
  endtask

  task automatic check_reads(input string req);
    bit en; int d;
    for (int b = 0; b < NB; b++) begin
      read_blk(b, en, d);
      chk(req, en, (model[b] == 2) ? 1 : 0);
      chk(req, d, (model[b] == 2) ? 255 : 0);
    end
  endtask

  task automatic start_flush();
    @(negedge clk);
    flush_start = 1'b1;
    @(negedge clk);
    flush_start = 1'b0;
  endtask

  // Acknowledges operations until done; compares against the model.
  task automatic drain_flush(input string req);
    int exp_blk [NB];
    int exp_er  [NB];
    int exp_n = 0;
    int n = 0;
    int cyc = 0;
    bit got_done = 1'b0;
    for (int b = 0; b < NB; b++)
      if (model[b] != 0) begin
        exp_blk[exp_n] = b; exp_er[exp_n] = (model[b] == 2) ? 1 : 0; exp_n++;
      end
    while (!got_done && cyc < 2000) begin
      if (flush_done) got_done = 1'b1;
      else if (flush_valid && !flush_ack) begin
        if (n < exp_n) begin
          chk({req, " R6 block"}, flush_blk, exp_blk[n]);
          chk({req, " R6 kind"}, flush_is_erase, exp_er[n]);
        end
        n++;
        flush_ack = 1'b1;
      end else flush_ack = 1'b0;
      if (!got_done) begin
        @(negedge clk);
        cyc++;
      end
    end
    flush_ack = 1'b0;
    chk({req, " R6 op count"}, n, exp_n);
    chk({req, " R7 done seen"}, got_done, 1);
    chk({req, " R7 busy low"}, busy, 0);
    for (int b = 0; b < NB; b++) model[b] = 0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; win_blocks = CW'(12); win_close = 1'b0;
    mark_valid = 1'b0; mark_erase = 1'b0; mark_off = '0; mark_cnt = '0;
    rd_valid = 1'b0; rd_addr = '0; flush_start = 1'b0; flush_ack = 1'b0;
    for (int b = 0; b < NB; b++) model[b] = 0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 busy", busy, 0);
    chk("R1 flush_valid", flush_valid, 0);
    chk("R1 flush_done", flush_done, 0);
    chk("R1 mark_ok", mark_ok, 0);
    chk("R1 mark_rej", mark_rej, 0);
    chk("R1 rd_ovr_en", rd_ovr_en, 0);
    check_reads("R1 clean map");
  endtask

  task automatic t_mark_basic();
    bit ok, rej;
    mark(2, 3, 1'b0, ok, rej); model_mark(2, 3, 1'b0);
    chk("R2 dirty ok", ok, 1); chk("R2 dirty rej", rej, 0);
    mark(6, 2, 1'b1, ok, rej); model_mark(6, 2, 1'b1);
    chk("R2 erase ok", ok, 1);
    check_reads("R4 erased read");
  endtask

  task automatic t_bounds();
    bit ok, rej;
    mark(10, 3, 1'b1, ok, rej);
    chk("R3 over window rej", rej, 1); chk("R3 over window ok", ok, 0);
    mark(9, 3, 1'b1, ok, rej); model_mark(9, 3, 1'b1);
    chk("R3 edge accepted", ok, 1);
    mark(12, 0, 1'b1, ok, rej);
    chk("R10 zero count ok", ok, 1);
    mark(13, 0, 1'b1, ok, rej);
    chk("R3 offset past window rej", rej, 1);
    check_reads("R3 state unchanged");
  endtask

  task automatic t_override();
    bit ok, rej;
    mark(3, 1, 1'b1, ok, rej); model_mark(3, 1, 1'b1);
    chk("R5 dirty->erased ok", ok, 1);
    mark(6, 1, 1'b0, ok, rej); model_mark(6, 1, 1'b0);
    chk("R5 erased->dirty ok", ok, 1);
    check_reads("R5 override");
  endtask

  task automatic t_flush();
    start_flush();
    drain_flush("flush");
    check_reads("R7 cleared");
    start_flush();
    drain_flush("R7 empty flush");
  endtask

  task automatic t_busy();
    bit ok, rej, en; int d; int cyc = 0;
    mark(0, 1, 1'b0, ok, rej); model_mark(0, 1, 1'b0);
    mark(8, 1, 1'b1, ok, rej); model_mark(8, 1, 1'b1);
    start_flush();
    while (!flush_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R8 busy high", busy, 1);
    mark(3, 1, 1'b1, ok, rej);
    chk("R8 mark rejected", rej, 1); chk("R8 mark not ok", ok, 0);
    chk("R6 still pending", flush_valid, 1);
    chk("R6 pending block", flush_blk, 0);
    read_blk(3, en, d); chk("R8 no change blk3", en, 0);
    read_blk(8, en, d); chk("R8 erased kept", en, 1);
    drain_flush("R8 flush");
  endtask

  task automatic t_close();
    bit ok, rej; int cyc = 0;
    mark(1, 2, 1'b1, ok, rej); model_mark(1, 2, 1'b1);
    mark(5, 1, 1'b0, ok, rej); model_mark(5, 1, 1'b0);
    start_flush();
    while (!flush_valid && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R6 first block", flush_blk, 1);
    chk("R6 first kind", flush_is_erase, 1);
    win_close = 1'b1;
    @(negedge clk);
    win_close = 1'b0;
    chk("R9 busy low", busy, 0);
    chk("R9 no op", flush_valid, 0);
    chk("R9 no done", flush_done, 0);
    for (int b = 0; b < NB; b++) model[b] = 0;
    check_reads("R9 cleared");
    start_flush();
    drain_flush("R9 after close");
  endtask

  task automatic t_full();
    bit ok, rej;
    win_blocks = CW'(16);
    mark(15, 1, 1'b1, ok, rej); model_mark(15, 1, 1'b1);
    chk("R3 last block ok", ok, 1);
    mark(0, 16, 1'b0, ok, rej); model_mark(0, 16, 1'b0);
    chk("R2 full window ok", ok, 1);
    mark(14, 3, 1'b0, ok, rej);
    chk("R3 beyond map rej", rej, 1);
    check_reads("R5 full window");
    start_flush();
    drain_flush("R6 full walk");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    miscmp++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end

  initial begin
    t_reset();
    t_mark_basic();
    t_bounds();
    t_override();
    t_flush();
    t_busy();
    t_close();
    t_full();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscmp);
    $finish;
  end
endmodule